// File: doc/BRIEF.md
# Event Queue Writer with Generation Bit

The block is the producer side of a circular interrupt-event queue. Each accepted notification, a 31-bit data word offered on a valid/ready handshake, is stored as a 32-bit entry at the producer index. The index then advances and wraps by masking with (entries - 1), because the depth is a power of two. Bit 31 of every stored entry carries a generation flag. The producer starts its generation at 1 and inverts it each time its index wraps to 0. A reader can therefore tell fresh entries from stale ones without any pointer being shared.

A consumer-side port models the software that polls the queue. It keeps its own index and toggle. The toggle starts at 0 over a zeroed memory and flips each time the consumer index wraps. An entry counts as present only when its bit 31 differs from that toggle; an absent entry reads as data 0. The block raises a notify pulse for accepted writes, either on every write or only when the queue was empty before the write. An occupancy counter stops the producer from overwriting entries that have not been consumed: such a write is dropped and flagged.

Top module: `evq_writer`

## Requirements
- R1: While reset is held and on the first cycle after it, rd_valid, rd_data, notify, overflow and rd_is_ipi are 0, in_ready is 1, and bit 31 of rd_entry is 0.
- R2: A word accepted on a clock edge (in_valid and in_ready high) is visible at the consumer port after that edge, once all earlier entries have been popped. Entries come out in the order they were accepted, with rd_data equal to the accepted in_data.
- R3: The stored word is {generation, in_data}. The producer generation starts at 1 and inverts when the producer index wraps to 0. The consumer toggle starts at 0 and inverts when the consumer index wraps to 0. rd_valid is high exactly when rd_entry[31] differs from the consumer toggle, so an empty queue shows a stale rd_entry whose bit 31 equals the toggle.
- R4: When rd_valid is low, rd_data is 0.
- R5: rd_pop advances the consumer index only while rd_valid is high. rd_pop on an empty queue leaves the consumer view unchanged.
- R6: With always_notify high, notify pulses for one cycle after every accepted write. With it low, notify pulses only for a write accepted while the occupancy was 0 before that edge.
- R7: A write offered while the occupancy equals the depth is dropped, even when a pop happens in the same cycle. overflow pulses for one cycle after the edge, and the queue contents are left unchanged.
- R8: in_ready is low exactly when the occupancy equals the depth.
- R9: rd_is_ipi is high exactly when rd_valid is high and rd_data equals 2^24, the inter-processor code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| always_notify | input | 1 | 1: notify on every write; 0: notify only on a write into an empty queue |
| in_valid | input | 1 | Notification offered |
| in_data | input | 31 | Notification data |
| in_ready | output | 1 | Queue has a free slot |
| notify | output | 1 | One-cycle notification pulse |
| overflow | output | 1 | One-cycle pulse: a write was dropped |
| rd_pop | input | 1 | Consumer advances past the head entry |
| rd_valid | output | 1 | Head entry is fresh |
| rd_data | output | 31 | Head data, 0 when empty |
| rd_entry | output | 32 | Raw word at the consumer index |
| rd_is_ipi | output | 1 | Head entry carries the inter-processor code |

## Verification
The hardest situation to reach is a queue that has wrapped many times, where stale words from the previous lap sit in memory with the opposite generation. Validity must then be decided by the flag alone. A full queue that receives a push and a pop in the same cycle is also difficult to hit. The bench reaches these states with directed fill, drain and overflow phases, followed by several thousand cycles of random push and pop traffic with the notify mode switching. On a small default depth this makes both indices wrap dozens of times. On every clock a behavioural queue model is checked against the flag bit of the raw word, both for fresh and for stale entries.

// File: rtl/evq_writer.sv
module evq_writer #(
  parameter int DEPTH_LOG2 = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        always_notify,
  input  logic        in_valid,
  input  logic [30:0] in_data,
  output logic        in_ready,
  output logic        notify,
  output logic        overflow,
  input  logic        rd_pop,
  output logic        rd_valid,
  output logic [30:0] rd_data,
  output logic [31:0] rd_entry,
  output logic        rd_is_ipi
);
  localparam int DEPTH = 1 << DEPTH_LOG2;
  localparam logic [DEPTH_LOG2-1:0] IDX_MASK = DEPTH_LOG2'(DEPTH - 1);
  localparam logic [DEPTH_LOG2-1:0] IDX_ONE  = DEPTH_LOG2'(1);
  localparam logic [DEPTH_LOG2:0]   OCC_ONE  = (DEPTH_LOG2+1)'(1);
  localparam logic [DEPTH_LOG2:0]   OCC_FULL = (DEPTH_LOG2+1)'(DEPTH);
  localparam logic [30:0]           IPI_CODE = 31'(1 << 24);

  logic [31:0]           mem [DEPTH];
  logic [DEPTH_LOG2-1:0] wr_idx, rd_idx, wr_nxt, rd_nxt;
  logic [DEPTH_LOG2:0]   occ;
  logic                  wr_gen, rd_tog;
  logic                  accept, pop_ok, full;

  assign full     = (occ == OCC_FULL);
  assign in_ready = !full;
  assign accept   = in_valid && !full;
  assign rd_entry = mem[rd_idx];
  assign rd_valid = rd_entry[31] != rd_tog;
  assign rd_data  = rd_valid ? rd_entry[30:0] : 31'd0;
  assign rd_is_ipi = rd_valid && (rd_entry[30:0] == IPI_CODE);
  assign pop_ok   = rd_pop && rd_valid;
  assign wr_nxt   = (wr_idx + IDX_ONE) & IDX_MASK;
  assign rd_nxt   = (rd_idx + IDX_ONE) & IDX_MASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (accept) begin
      mem[wr_idx] <= {wr_gen, in_data};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_idx <= '0;
      wr_gen <= 1'b1;
    end else if (accept) begin
      wr_idx <= wr_nxt;
      if (wr_nxt == '0) wr_gen <= !wr_gen;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_idx <= '0;
      rd_tog <= 1'b0;
    end else if (pop_ok) begin
      rd_idx <= rd_nxt;
      if (rd_nxt == '0) rd_tog <= !rd_tog;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ      <= '0;
      notify   <= 1'b0;
      overflow <= 1'b0;
    end else begin
      if (accept && !pop_ok)      occ <= occ + OCC_ONE;
      else if (!accept && pop_ok) occ <= occ - OCC_ONE;
      notify   <= accept && (always_notify || occ == '0);
      overflow <= in_valid && full;
    end
  end
endmodule

module evq_writer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        always_notify,
  input logic        in_valid,
  input logic [30:0] in_data,
  input logic        in_ready,
  input logic        notify,
  input logic        overflow,
  input logic        rd_pop,
  input logic        rd_valid,
  input logic [30:0] rd_data,
  input logic [31:0] rd_entry,
  input logic        rd_is_ipi
);
  assert_empty_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> rd_data == 31'd0);

  assert_notify_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
    notify |-> $past(in_valid && in_ready));

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> $past(in_valid && !in_ready));

  assert_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(notify && overflow));

  assert_ipi_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_is_ipi |-> rd_valid);

  assert_empty_pop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pop && !rd_valid && !(in_valid && in_ready)) |=> $stable(rd_entry));
endmodule

bind evq_writer evq_writer_chk chk (.*);

// File: tb/evq_writer_test.sv
`timescale 1ns/1ps
module evq_writer_test;
  localparam int LG = 3;
  localparam int DEPTH = 1 << LG;

  logic clk = 0, rst_n = 0;
  logic always_notify = 0, in_valid = 0, rd_pop = 0;
  logic [30:0] in_data = '0;
  logic in_ready, notify, overflow, rd_valid, rd_is_ipi;
  logic [30:0] rd_data;
  logic [31:0] rd_entry;

  evq_writer #(.DEPTH_LOG2(LG)) uut (.*);

  always #5 clk = ~clk;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [31:0] q[$];
  int wcount = 0, pcount = 0;
  bit e_notify = 0, e_ovf = 0;

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    bit v = q.size() > 0;
    bit ctog = ((pcount / DEPTH) % 2) == 1;
    chk("R2/R3 rd_valid", rd_valid, v);
    chk("R2/R4 rd_data", rd_data, v ? q[0][30:0] : 0);
    chk("R3 rd_entry gen", rd_entry[31], v ? q[0][31] : ctog);
    chk("R6 notify", notify, e_notify);
    chk("R7 overflow", overflow, e_ovf);
    chk("R8 in_ready", in_ready, q.size() != DEPTH);
    chk("R9 rd_is_ipi", rd_is_ipi, v && q[0][30:0] == 31'(1 << 24));
  endtask

  task automatic step(input bit v, input logic [30:0] d, input bit p);
    int sz0;
    bit push_ok, pop_ok;
    in_valid = v; in_data = d; rd_pop = p;
    @(posedge clk);
    sz0 = q.size();
    e_ovf = v && sz0 == DEPTH;
    push_ok = v && !e_ovf;
    pop_ok = p && sz0 > 0;
    e_notify = push_ok && (always_notify || sz0 == 0);
    if (pop_ok) begin void'(q.pop_front()); pcount++; end
    if (push_ok) begin
      q.push_back({((wcount / DEPTH) % 2) == 0, d});
      wcount++;
    end
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset rd_valid", rd_valid, 0);
    chk("R1 reset notify", notify, 0);
    chk("R1 reset in_ready", in_ready, 1);
    rst_n = 1;
    @(negedge clk);
    compare_all();
    chk("R1 reset gen bit", rd_entry[31], 0);

    // R6: notify only on empty when mode off
    always_notify = 0;
    step(1, 31'h11, 0);
    step(1, 31'h22, 0);
    step(1, 31'h33, 0);
    // R2/R5: drain in order, then pop on empty is ignored
    repeat (4) step(0, 0, 1);
    step(0, 0, 1);
    // R7/R8: fill, overflow, overflow with simultaneous pop
    for (int i = 0; i < DEPTH; i++) step(1, 31'(100 + i), 0);
    step(1, 31'h7777, 0);
    step(1, 31'h7778, 1);
    repeat (DEPTH) step(0, 0, 1);
    // R6: always-notify mode
    always_notify = 1;
    for (int i = 0; i < 4; i++) step(1, 31'(200 + i), 0);
    // R9: inter-processor code
    step(1, 31'(1 << 24), 1);
    repeat (5) step(0, 0, 1);
    // R3: random traffic across many wraps
    for (int i = 0; i < 4000; i++) begin
      if (i % 500 == 0) always_notify = ~always_notify;
      step(($urandom % 100) < 55, ($urandom % 8 == 0) ? 31'(1 << 24) : 31'($urandom | 1),
           ($urandom % 100) < ((i / 250) % 2 ? 70 : 35));
    end
    repeat (DEPTH + 2) step(0, 0, 1);

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule